// File: doc/BRIEF.md
# Batching Vertex Cache and Shader Dispatcher

This block sits between index fetch and the shader array. It receives triangles as three vertex indices and, within the batch currently being filled, gives each vertex a slot. Every index is compared in parallel against a fully associative tag store. A match returns the slot that already holds that vertex. A non-match claims the next free slot and records the index there. For each accepted triangle the block emits a record containing the batch number and three slot numbers. Primitive assembly later uses that record to locate the shaded vertices.

A batch closes when fewer than three slots remain and another triangle is waiting, or when a flush is requested at the end of a draw. The list of unique indices in the closed batch is handed to a shader unit, and the tag store is emptied. Because no vertex is shared between batches, every batch is independent and several can be in flight at once. Units are chosen in rotation. A closed batch waits at the output while its target unit is busy.

Top module: `vtx_batcher`

## Requirements
- R1: After reset, `tri_ready` is 1 and `rec_valid` and `disp_valid` are 0. The first batch has ID 0 and is sent to unit 0.
- R2: Indices not yet present in the current batch take consecutive slots starting at 0. Within one triangle they are allocated in the order idx0, idx1, idx2.
- R3: An index already present in the current batch reuses its existing slot and uses no new slot.
- R4: Indices repeated within one triangle share a single slot.
- R5: One cycle after a triangle is accepted (`tri_valid` and `tri_ready` high at a clock edge), `rec_valid` is 1 for one cycle. `rec_bid` carries the ID of the batch being built, and `rec_slot0..2` carry the three slots.
- R6: A triangle is accepted only while at least 3 slots are free, whether or not its indices would hit. Otherwise `tri_ready` is 0 and the batch is closed on that edge. The triangle is then accepted into a new batch whose cache is empty, so previously seen indices get fresh slots.
- R7: `disp_valid` rises the cycle after a batch closes. `disp_count` is the number of unique indices in the batch. Field k of `disp_tags` (bits k*IDX_W upward) holds the index assigned to slot k, and fields at k >= `disp_count` are 0.
- R8: Successive batches go to units 0, 1, 2, 3, 0, … in turn. Batch IDs increase by one per batch, modulo 2^BID_W.
- R9: While `unit_busy[disp_unit]` is 1, `disp_valid` stays 1 and the dispatch fields stay unchanged. The batch is taken at the first edge where that bit is 0. A further batch cannot close while one is still waiting.
- R10: A `flush` pulse while the current batch holds at least one vertex closes and dispatches it. A `flush` while the batch is empty dispatches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tri_valid | input | 1 | Triangle offered |
| tri_ready | output | 1 | Triangle accepted this edge |
| tri_idx0 | input | IDX_W | First vertex index |
| tri_idx1 | input | IDX_W | Second vertex index |
| tri_idx2 | input | IDX_W | Third vertex index |
| flush | input | 1 | Close a partial batch at end of draw |
| rec_valid | output | 1 | Triangle slot record valid |
| rec_bid | output | BID_W | Batch ID of the record |
| rec_slot0 | output | SLOT_W | Slot of first vertex |
| rec_slot1 | output | SLOT_W | Slot of second vertex |
| rec_slot2 | output | SLOT_W | Slot of third vertex |
| unit_busy | input | UNITS | Per-unit busy flags |
| disp_valid | output | 1 | Batch waiting for its unit |
| disp_unit | output | UNIT_W | Target shader unit |
| disp_bid | output | BID_W | Batch ID |
| disp_count | output | CNT_W | Unique vertices in batch |
| disp_tags | output | SLOTS*IDX_W | Index per slot, zero beyond count |

## Verification
A stale valid bit left in the tag store after a batch closes shows up on the very next record. There, a repeated index returns its old slot number instead of restarting at 0. A wrong fill count shows up in two places. Either `tri_ready` drops one triangle too early or too late relative to the 3-free-slot rule, or `disp_count` and the zeroed tail of `disp_tags` disagree with the number of unique indices sent. Rotation and batch-ID faults appear in the first few dispatches after reset, and a hold fault appears while a unit reports busy.

// File: rtl/vb_pkg.sv
package vb_pkg;

  // Number of vertex slots a triangle will consume, given which of its
  // three lanes need a fresh slot.
  function automatic int unsigned fresh_total(input logic n0, input logic n1, input logic n2);
    return int'(n0) + int'(n1) + int'(n2);
  endfunction

  // Conservative admission: three free slots regardless of hits.
  function automatic logic fits_triangle(input int unsigned filled, input int unsigned cap);
    return (filled + 3) <= cap;
  endfunction

  // Round-robin successor.
  function automatic int unsigned rr_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 == n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/vb_tag_cam.sv
module vb_tag_cam #(
  parameter int SLOTS  = 32,
  parameter int IDX_W  = 16,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic [2:0]                   wr_en,
  input  logic [2:0][SLOT_W-1:0]       wr_slot,
  input  logic [2:0][IDX_W-1:0]        wr_idx,
  input  logic [2:0][IDX_W-1:0]        lk_idx,
  output logic [2:0]                   hit,
  output logic [2:0][SLOT_W-1:0]       hit_slot,
  output logic [SLOTS*IDX_W-1:0]       tags_flat
);

  logic [IDX_W-1:0] tag_q [SLOTS];
  logic [SLOTS-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      vld_q <= '0;
      for (int j = 0; j < SLOTS; j++) tag_q[j] <= '0;
    end else begin
      for (int p = 0; p < 3; p++) begin
        if (wr_en[p]) begin
          tag_q[wr_slot[p]] <= wr_idx[p];
          vld_q[wr_slot[p]] <= 1'b1;
        end
      end
    end
  end

  for (genvar j = 0; j < SLOTS; j++) begin : g_flat
    assign tags_flat[j*IDX_W +: IDX_W] = tag_q[j];
  end

  for (genvar p = 0; p < 3; p++) begin : g_port
    logic [SLOTS-1:0] match;
    always_comb begin
      for (int j = 0; j < SLOTS; j++) match[j] = vld_q[j] && (tag_q[j] == lk_idx[p]);
    end
    assign hit[p] = |match;
    always_comb begin
      hit_slot[p] = '0;
      for (int j = 0; j < SLOTS; j++)
        if (match[j]) hit_slot[p] = hit_slot[p] | SLOT_W'(j);
    end

    // R4 R3
    // one_match_chk
    always_ff @(posedge clk) begin
      if (rst_n) one_match_chk: assert ($onehot0(match));
    end
  end

  // R6
  property cleared_empty_p;
    @(posedge clk) disable iff (!rst_n) clear |=> (vld_q == '0);
  endproperty
  cleared_empty_chk: assert property (cleared_empty_p);

endmodule

// File: rtl/vb_slot_alloc.sv
module vb_slot_alloc
  import vb_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int IDX_W  = 16,
  parameter int SLOT_W = $clog2(SLOTS),
  parameter int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic [2:0][IDX_W-1:0]  idx,
  input  logic [2:0]             hit,
  input  logic [2:0][SLOT_W-1:0] hit_slot,
  input  logic [CNT_W-1:0]       filled,
  output logic [2:0][SLOT_W-1:0] slot,
  output logic [2:0]             fresh,
  output logic [CNT_W-1:0]       grow
);

  logic [CNT_W-1:0] base1, base2;
  logic dup10, dup20, dup21;

  always_comb begin
    dup10 = (idx[1] == idx[0]);
    dup20 = (idx[2] == idx[0]);
    dup21 = (idx[2] == idx[1]);

    fresh[0] = !hit[0];
    fresh[1] = !hit[1] && !dup10;
    fresh[2] = !hit[2] && !dup20 && !dup21;

    base1 = filled + CNT_W'(fresh[0]);
    base2 = base1 + CNT_W'(fresh[1]);

    slot[0] = hit[0] ? hit_slot[0] : filled[SLOT_W-1:0];
    if (hit[1])      slot[1] = hit_slot[1];
    else if (dup10)  slot[1] = slot[0];
    else             slot[1] = base1[SLOT_W-1:0];
    if (hit[2])      slot[2] = hit_slot[2];
    else if (dup20)  slot[2] = slot[0];
    else if (dup21)  slot[2] = slot[1];
    else             slot[2] = base2[SLOT_W-1:0];

    grow = CNT_W'(fresh_total(fresh[0], fresh[1], fresh[2]));
  end

endmodule

// File: rtl/vb_dispatch.sv
module vb_dispatch
  import vb_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int IDX_W  = 16,
  parameter int UNITS  = 4,
  parameter int BID_W  = 8,
  parameter int CNT_W  = $clog2(SLOTS + 1),
  parameter int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   close_go,
  input  logic [CNT_W-1:0]       close_count,
  input  logic [SLOTS*IDX_W-1:0] close_tags,
  input  logic [UNITS-1:0]       unit_busy,
  output logic                   slot_free,
  output logic [BID_W-1:0]       build_bid,
  output logic                   disp_valid,
  output logic [UNIT_W-1:0]      disp_unit,
  output logic [BID_W-1:0]       disp_bid,
  output logic [CNT_W-1:0]       disp_count,
  output logic [SLOTS*IDX_W-1:0] disp_tags
);

  logic [UNIT_W-1:0] unit_q;
  logic              taken;

  assign taken     = disp_valid && !unit_busy[disp_unit];
  assign slot_free = !disp_valid || taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_unit  <= '0;
      disp_bid   <= '0;
      disp_count <= '0;
      disp_tags  <= '0;
      unit_q     <= '0;
      build_bid  <= '0;
    end else begin
      if (close_go) begin
        disp_valid <= 1'b1;
        disp_unit  <= unit_q;
        disp_bid   <= build_bid;
        disp_count <= close_count;
        disp_tags  <= close_tags;
        unit_q     <= UNIT_W'(rr_next(int'(unit_q), UNITS));
        build_bid  <= build_bid + 1'b1;
      end else if (taken) begin
        disp_valid <= 1'b0;
      end
    end
  end

  // R10
  property no_empty_p;
    @(posedge clk) disable iff (!rst_n) close_go |-> (close_count != '0);
  endproperty
  no_empty_chk: assert property (no_empty_p);

  // R9
  property hold_busy_p;
    @(posedge clk) disable iff (!rst_n)
      (disp_valid && unit_busy[disp_unit]) |=> (disp_valid && $stable(disp_bid) && $stable(disp_count));
  endproperty
  hold_busy_chk: assert property (hold_busy_p);

  // R9
  property no_overwrite_p;
    @(posedge clk) disable iff (!rst_n) close_go |-> slot_free;
  endproperty
  no_overwrite_chk: assert property (no_overwrite_p);

  // R8
  property bid_step_p;
    @(posedge clk) disable iff (!rst_n) close_go |=> (disp_bid == $past(build_bid));
  endproperty
  bid_step_chk: assert property (bid_step_p);

endmodule

// File: rtl/vtx_batcher.sv
module vtx_batcher
  import vb_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int IDX_W  = 16,
  parameter int UNITS  = 4,
  parameter int BID_W  = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tri_valid,
  output logic                   tri_ready,
  input  logic [IDX_W-1:0]       tri_idx0,
  input  logic [IDX_W-1:0]       tri_idx1,
  input  logic [IDX_W-1:0]       tri_idx2,
  input  logic                   flush,
  output logic                   rec_valid,
  output logic [BID_W-1:0]       rec_bid,
  output logic [SLOT_W-1:0]      rec_slot0,
  output logic [SLOT_W-1:0]      rec_slot1,
  output logic [SLOT_W-1:0]      rec_slot2,
  input  logic [UNITS-1:0]       unit_busy,
  output logic                   disp_valid,
  output logic [UNIT_W-1:0]      disp_unit,
  output logic [BID_W-1:0]       disp_bid,
  output logic [CNT_W-1:0]       disp_count,
  output logic [SLOTS*IDX_W-1:0] disp_tags
);

  logic [CNT_W-1:0]       filled_q;
  logic [2:0][IDX_W-1:0]  idx;
  logic [2:0]             hit, fresh;
  logic [2:0][SLOT_W-1:0] hit_slot, slot;
  logic [CNT_W-1:0]       grow;
  logic [SLOTS*IDX_W-1:0] tags_now;
  logic [BID_W-1:0]       build_bid;
  logic                   room, nonempty, close_req, close_go, slot_free, tri_take;

  assign idx = {tri_idx2, tri_idx1, tri_idx0};

  // Named internal events
  assign room      = fits_triangle(int'(filled_q), SLOTS);
  assign nonempty  = (filled_q != '0);
  assign close_req = nonempty && ((tri_valid && !room) || flush);
  assign close_go  = close_req && slot_free;
  assign tri_ready = room && !(flush && nonempty);
  assign tri_take  = tri_valid && tri_ready;

  vb_tag_cam #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (close_go),
    .wr_en    (fresh & {3{tri_take}}),
    .wr_slot  (slot),
    .wr_idx   (idx),
    .lk_idx   (idx),
    .hit      (hit),
    .hit_slot (hit_slot),
    .tags_flat(tags_now)
  );

  vb_slot_alloc #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_alloc (
    .idx     (idx),
    .hit     (hit),
    .hit_slot(hit_slot),
    .filled  (filled_q),
    .slot    (slot),
    .fresh   (fresh),
    .grow    (grow)
  );

  vb_dispatch #(.SLOTS(SLOTS), .IDX_W(IDX_W), .UNITS(UNITS), .BID_W(BID_W),
                .CNT_W(CNT_W), .UNIT_W(UNIT_W)) u_disp (
    .clk        (clk),
    .rst_n      (rst_n),
    .close_go   (close_go),
    .close_count(filled_q),
    .close_tags (tags_now),
    .unit_busy  (unit_busy),
    .slot_free  (slot_free),
    .build_bid  (build_bid),
    .disp_valid (disp_valid),
    .disp_unit  (disp_unit),
    .disp_bid   (disp_bid),
    .disp_count (disp_count),
    .disp_tags  (disp_tags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filled_q  <= '0;
      rec_valid <= 1'b0;
      rec_bid   <= '0;
      rec_slot0 <= '0;
      rec_slot1 <= '0;
      rec_slot2 <= '0;
    end else begin
      rec_valid <= tri_take;
      if (close_go)      filled_q <= '0;
      else if (tri_take) filled_q <= filled_q + grow;
      if (tri_take) begin
        rec_bid   <= build_bid;
        rec_slot0 <= slot[0];
        rec_slot1 <= slot[1];
        rec_slot2 <= slot[2];
      end
    end
  end

  // R6
  property admit_room_p;
    @(posedge clk) disable iff (!rst_n) tri_take |-> (filled_q <= CNT_W'(SLOTS - 3));
  endproperty
  admit_room_chk: assert property (admit_room_p);

  // R6
  property fill_bound_p;
    @(posedge clk) disable iff (!rst_n) 1'b1 |-> (filled_q <= CNT_W'(SLOTS));
  endproperty
  fill_bound_chk: assert property (fill_bound_p);

  // R5
  property rec_follow_p;
    @(posedge clk) disable iff (!rst_n) tri_take |=> rec_valid;
  endproperty
  rec_follow_chk: assert property (rec_follow_p);

  // R10
  property flush_close_p;
    @(posedge clk) disable iff (!rst_n) (flush && nonempty && slot_free) |=> (filled_q == '0 && disp_valid);
  endproperty
  flush_close_chk: assert property (flush_close_p);

endmodule

// File: tb/tb_vtx_batcher.sv
module tb_vtx_batcher;
  localparam int SLOTS = 32, IDX_W = 16, UNITS = 4, BID_W = 8;
  localparam int SLOT_W = $clog2(SLOTS), CNT_W = $clog2(SLOTS + 1), UNIT_W = 2;

  logic clk = 0, rst_n = 0, tri_valid = 0, flush = 0;
  logic tri_ready, rec_valid, disp_valid;
  logic [IDX_W-1:0] i0 = 0, i1 = 0, i2 = 0;
  logic [BID_W-1:0] rec_bid, disp_bid;
  logic [SLOT_W-1:0] s0, s1, s2;
  logic [UNITS-1:0] unit_busy = 0;
  logic [UNIT_W-1:0] disp_unit;
  logic [CNT_W-1:0] disp_count;
  logic [SLOTS*IDX_W-1:0] disp_tags;

  always #5 clk = ~clk;

  vtx_batcher #(.SLOTS(SLOTS), .IDX_W(IDX_W), .UNITS(UNITS), .BID_W(BID_W)) dut (
    .clk(clk), .rst_n(rst_n), .tri_valid(tri_valid), .tri_ready(tri_ready),
    .tri_idx0(i0), .tri_idx1(i1), .tri_idx2(i2), .flush(flush),
    .rec_valid(rec_valid), .rec_bid(rec_bid), .rec_slot0(s0), .rec_slot1(s1), .rec_slot2(s2),
    .unit_busy(unit_busy), .disp_valid(disp_valid), .disp_unit(disp_unit),
    .disp_bid(disp_bid), .disp_count(disp_count), .disp_tags(disp_tags));

  int n_chk = 0, n_bad = 0, stalls = 0, nlog = 0;
  logic [BID_W-1:0] lg_bid [8];
  logic [UNIT_W-1:0] lg_unit [8];
  logic [CNT_W-1:0] lg_cnt [8];
  logic [SLOTS*IDX_W-1:0] lg_tags [8];

  // i0,i1,i2, expected slots s0,s1,s2, requirement number shown in message
  localparam int TBL [6][7] = '{
    '{0, 1, 2, 0, 1, 2, 2},
    '{2, 1, 3, 2, 1, 3, 3},
    '{5, 5, 4, 4, 4, 5, 4},
    '{4, 6, 6, 5, 6, 6, 4},
    '{7, 7, 7, 7, 7, 7, 4},
    '{0, 3, 7, 0, 3, 7, 3}};

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Batch log: a dispatch seen valid with its unit free is taken at the next edge.
  always begin
    @(negedge clk); #1;
    if (rst_n && disp_valid && !unit_busy[disp_unit] && nlog < 8) begin
      lg_bid[nlog] = disp_bid; lg_unit[nlog] = disp_unit;
      lg_cnt[nlog] = disp_count; lg_tags[nlog] = disp_tags;
      nlog++;
    end
  end

  task automatic send(input int a, input int b, input int c);
    @(negedge clk);
    tri_valid = 1; i0 = IDX_W'(a); i1 = IDX_W'(b); i2 = IDX_W'(c);
    #1;
    while (!tri_ready) begin stalls++; @(negedge clk); #1; end
    @(negedge clk);
    tri_valid = 0;
  endtask

  task automatic expect_rec(input int e0, input int e1, input int e2, input int eb, input string req);
    chk(rec_valid === 1'b1, {req, " rec_valid"}, rec_valid, 1);
    chk(s0 == SLOT_W'(e0), {req, " slot0"}, s0, e0);
    chk(s1 == SLOT_W'(e1), {req, " slot1"}, s1, e1);
    chk(s2 == SLOT_W'(e2), {req, " slot2"}, s2, e2);
    chk(rec_bid == BID_W'(eb), {req, " R5 bid"}, rec_bid, eb);
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  function automatic int tag_at(input logic [SLOTS*IDX_W-1:0] t, input int k);
    return int'(t[k*IDX_W +: IDX_W]);
  endfunction

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tri_ready === 1'b1, "R1 ready", tri_ready, 1);
    chk(rec_valid === 1'b0, "R1 rec", rec_valid, 0);
    chk(disp_valid === 1'b0, "R1 disp", disp_valid, 0);
    rst_n = 1;

    // Table walk: R2 allocation order, R3 hits, R4 duplicates, R5 record
    for (int t = 0; t < 6; t++) begin
      send(TBL[t][0], TBL[t][1], TBL[t][2]);
      expect_rec(TBL[t][3], TBL[t][4], TBL[t][5], 0, $sformatf("R%0d", TBL[t][6]));
    end

    // Fill to 32 slots with fresh indices (R2)
    for (int k = 0; k < 8; k++) begin
      send(100 + 3*k, 101 + 3*k, 102 + 3*k);
      expect_rec(8 + 3*k, 9 + 3*k, 10 + 3*k, 0, "R2");
    end
    chk(stalls == 0, "R6 no early stall", stalls, 0);

    // Full batch: next triangle stalls, goes to batch 1 with empty cache (R6)
    send(0, 1, 2);
    chk(stalls == 1, "R6 stall", stalls, 1);
    expect_rec(0, 1, 2, 1, "R6");
    repeat (2) @(negedge clk);
    chk(nlog == 1, "R7 dispatched", nlog, 1);
    chk(lg_unit[0] == 0, "R1 unit0", lg_unit[0], 0);
    chk(lg_bid[0] == 0, "R1 bid0", lg_bid[0], 0);
    chk(lg_cnt[0] == 32, "R7 count", lg_cnt[0], 32);
    chk(tag_at(lg_tags[0], 4) == 5, "R7 slot4", tag_at(lg_tags[0], 4), 5);
    chk(tag_at(lg_tags[0], 5) == 4, "R7 slot5", tag_at(lg_tags[0], 5), 4);
    chk(tag_at(lg_tags[0], 8) == 100, "R7 slot8", tag_at(lg_tags[0], 8), 100);
    chk(tag_at(lg_tags[0], 31) == 123, "R7 slot31", tag_at(lg_tags[0], 31), 123);

    // Flush partial batch 1 while unit 1 busy (R9, R10)
    unit_busy = 4'b0010;
    pulse_flush();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #2;
      chk(disp_valid === 1'b1 && disp_bid == 1, "R9 hold", disp_bid, 1);
      chk(disp_unit == 1, "R9 unit", disp_unit, 1);
    end
    chk(nlog == 1, "R9 not taken", nlog, 1);
    @(negedge clk); unit_busy = 0;
    repeat (2) @(negedge clk);
    chk(nlog == 2, "R10 flushed", nlog, 2);
    chk(lg_cnt[1] == 3, "R7 partial count", lg_cnt[1], 3);
    chk(tag_at(lg_tags[1], 2) == 2, "R7 tag2", tag_at(lg_tags[1], 2), 2);
    chk(tag_at(lg_tags[1], 3) == 0, "R7 zero tail", tag_at(lg_tags[1], 3), 0);
    chk(disp_valid === 1'b0, "R9 released", disp_valid, 0);

    // Round-robin over batches 2..4 (R8)
    for (int b = 2; b < 5; b++) begin
      send(200, 201, 200);
      expect_rec(0, 1, 0, b, "R8");
      pulse_flush();
      repeat (2) @(negedge clk);
    end
    chk(nlog == 5, "R8 count", nlog, 5);
    chk(lg_unit[2] == 2 && lg_unit[3] == 3 && lg_unit[4] == 0, "R8 units", lg_unit[4], 0);
    chk(lg_bid[2] == 2 && lg_bid[3] == 3 && lg_bid[4] == 4, "R8 bids", lg_bid[4], 4);
    chk(lg_cnt[4] == 2, "R4 count", lg_cnt[4], 2);

    // Empty flush dispatches nothing (R10)
    pulse_flush();
    repeat (4) @(negedge clk);
    chk(nlog == 5, "R10 empty flush", nlog, 5);
    chk(disp_valid === 1'b0, "R10 idle", disp_valid, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule